// File: doc/BRIEF.md
# Foreground Sprite Slot

This block is one foreground sprite slot of a tile-based picture generator. A chip instantiates one slot per sprite it supports. Each slot keeps a private copy of its 32-bit attribute word: position, tile number, mirror bits and palette choice. The copy is reloaded from the shared attribute store only while the display is in vertical blanking, so the slot never sees a half-updated sprite in the middle of a frame.

For every pixel coordinate presented, the slot decides whether its 16x16 sprite covers that pixel. It forms the address of the matching texel in the shared tilemap memory, with the mirror bits applied, and sends that address to the memory. One cycle later the texel comes back from the synchronous memory. The slot then outputs a colour index qualified by its palette. The index appears only while the compositor grants this slot its enable.

Positions are stored with a bias of 15. A sprite can therefore hang off the left and top edges as well as the right and bottom edges.

Top module: `fg_sprite_slot`

## Requirements
- R1: Asynchronous active-low reset clears the cached attribute word to all zeros. It also clears both pipeline stages, so `hit_o` is 0 and `cidx_o` is 0 after reset.
- R2: Attribute word layout: bits [9:0] tile number, bit 10 horizontal mirror, bit 11 vertical mirror, bits [14:12] palette, bits [23:15] X position, bits [31:24] Y position.
- R3: The sprite covers pixel (x, y) exactly when 0 <= x + 15 - posx <= 15 and 0 <= y + 15 - posy <= 15. The arithmetic is signed and never wraps. A stored value of 0 therefore places the sprite 15 pixels past the left or top edge.
- R4: The tilemap address is tile*256 + row*16 + col, where col = x + 15 - posx and row = y + 15 - posy. It appears on `tmm_addr_o` one clock after the pixel coordinate is presented.
- R5: When the horizontal mirror bit is set, col is replaced by 15 - col. When the vertical mirror bit is set, row is replaced by 15 - row.
- R6: Two clocks after a pixel coordinate is presented, `hit_o` gives that pixel's cover decision. When the pixel is covered and the slot is enabled, `cidx_o` = {palette, texel}, with the palette in bits [5:3] and the texel read from `tmm_data_i` in bits [2:0]. The memory returns the texel one clock after it receives the address.
- R7: `cidx_o` is 0 whenever `cmp_en_i` is low or the current result is not covered. `hit_o` does not depend on the enable.
- R8: A new attribute word is taken only on a clock where both `attr_load_i` and `vblank_i` are high. A load strobe outside vertical blanking leaves the cached word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vblank_i | input | 1 | High during vertical blanking |
| attr_load_i | input | 1 | Strobe for the attribute word from the shared store |
| attr_word_i | input | 32 | Attribute word (layout in R2) |
| pix_x_i | input | 9 | Current pixel column |
| pix_y_i | input | 8 | Current pixel row |
| tmm_addr_o | output | 18 | Texel address to the tilemap memory |
| tmm_data_i | input | 3 | Texel returned by the tilemap memory |
| cmp_en_i | input | 1 | Output enable from the compositor |
| hit_o | output | 1 | Sprite covers the pixel (two-clock latency) |
| cidx_o | output | 6 | Palette-qualified colour index |

## Verification
The cover test, address and colour are checked with a full sweep of a window of pixels around each sprite. The sprite is placed at the top-left corner, in the interior, clipped at the left edge and clipped at the bottom-right corner. All four combinations of the mirror bits are used, together with distinct tile and palette values.

The sweep reaches one pixel past each edge. This separates an off-by-one in the bias from a correct window. It also exposes arithmetic that wraps instead of rejecting negative offsets.

The modelled memory returns a texel that depends on the row and column bits. A mirror applied to the wrong axis therefore gives a different colour, as does a swapped address field.

Load strobes are applied outside vertical blanking, and vertical blanking is applied without a strobe. In both cases the pixels that follow must still follow the old sprite. Pixels presented with the enable low must give a zero colour index while still reporting a hit.

// File: rtl/fgspr_pkg.sv
package fgspr_pkg;
  localparam int TILE_W  = 10;
  localparam int PAL_W   = 3;
  localparam int X_W     = 9;
  localparam int Y_W     = 8;
  localparam int TEXEL_W = 3;
  localparam int SIDE_LG = 4;
  localparam int BIAS    = 15;
  localparam int WORD_W  = Y_W + X_W + PAL_W + 2 + TILE_W;

  typedef struct packed {
    logic [Y_W-1:0]    pos_y;
    logic [X_W-1:0]    pos_x;
    logic [PAL_W-1:0]  pal;
    logic              vmirror;
    logic              hmirror;
    logic [TILE_W-1:0] tile;
  } fg_attr_t;
endpackage

// File: rtl/spr_attr_cache.sv
module spr_attr_cache
  import fgspr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vblank_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output fg_attr_t          attr_o
);
  fg_attr_t attr_q, attr_d;
  logic     take;

  always_comb begin
    take   = vblank_i && load_i;
    attr_d = attr_q;
    if (take) attr_d = fg_attr_t'(word_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) attr_q <= '0;
    else        attr_q <= attr_d;
  end

  assign attr_o = attr_q;

  AST_CACHE_FROZEN_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_i |=> $stable(attr_q)); // R8

  AST_CACHE_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank_i && load_i) |=> (attr_q == fg_attr_t'($past(word_i)))); // R8
endmodule

// File: rtl/spr_axis_hit.sv
module spr_axis_hit #(
  parameter int COORD_W = 9,
  parameter int SIDE_LG = 4,
  parameter int BIAS    = 15
) (
  input  logic [COORD_W-1:0] coord_i,
  input  logic [COORD_W-1:0] pos_i,
  input  logic               mirror_i,
  output logic               inside_o,
  output logic [SIDE_LG-1:0] idx_o
);
  localparam int DW = COORD_W + 2;

  logic [DW-1:0] diff;

  always_comb begin
    diff     = {2'b00, coord_i} + DW'(BIAS) - {2'b00, pos_i};
    inside_o = (diff[DW-1:SIDE_LG] == '0);
    idx_o    = diff[SIDE_LG-1:0] ^ {SIDE_LG{mirror_i}};
  end
endmodule

// File: rtl/fg_sprite_slot.sv
module fg_sprite_slot
  import fgspr_pkg::*;
#(
  parameter int ADDR_W = TILE_W + 2*SIDE_LG,
  parameter int CIDX_W = PAL_W + TEXEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               vblank_i,
  input  logic               attr_load_i,
  input  logic [WORD_W-1:0]  attr_word_i,
  input  logic [X_W-1:0]     pix_x_i,
  input  logic [Y_W-1:0]     pix_y_i,
  output logic [ADDR_W-1:0]  tmm_addr_o,
  input  logic [TEXEL_W-1:0] tmm_data_i,
  input  logic               cmp_en_i,
  output logic               hit_o,
  output logic [CIDX_W-1:0]  cidx_o
);
  fg_attr_t            attr;
  logic                in_x, in_y;
  logic [SIDE_LG-1:0]  col, row;

  logic                s1_hit_d, s1_hit_q;
  logic [PAL_W-1:0]    s1_pal_q;
  logic [ADDR_W-1:0]   addr_d, addr_q;
  logic                s2_hit_q;
  logic [PAL_W-1:0]    s2_pal_q;
  logic                past_ok_q;

  spr_attr_cache u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .vblank_i (vblank_i),
    .load_i   (attr_load_i),
    .word_i   (attr_word_i),
    .attr_o   (attr)
  );

  spr_axis_hit #(.COORD_W(X_W), .SIDE_LG(SIDE_LG), .BIAS(BIAS)) u_axis_x (
    .coord_i  (pix_x_i),
    .pos_i    (attr.pos_x),
    .mirror_i (attr.hmirror),
    .inside_o (in_x),
    .idx_o    (col)
  );

  spr_axis_hit #(.COORD_W(Y_W), .SIDE_LG(SIDE_LG), .BIAS(BIAS)) u_axis_y (
    .coord_i  (pix_y_i),
    .pos_i    (attr.pos_y),
    .mirror_i (attr.vmirror),
    .inside_o (in_y),
    .idx_o    (row)
  );

  always_comb begin
    s1_hit_d = in_x && in_y;
    addr_d   = {attr.tile, row, col};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_hit_q  <= 1'b0;
      s1_pal_q  <= '0;
      addr_q    <= '0;
      s2_hit_q  <= 1'b0;
      s2_pal_q  <= '0;
      past_ok_q <= 1'b0;
    end else begin
      s1_hit_q  <= s1_hit_d;
      s1_pal_q  <= attr.pal;
      addr_q    <= addr_d;
      s2_hit_q  <= s1_hit_q;
      s2_pal_q  <= s1_pal_q;
      past_ok_q <= 1'b1;
    end
  end

  assign tmm_addr_o = addr_q;
  assign hit_o      = s2_hit_q;
  assign cidx_o     = (cmp_en_i && s2_hit_q) ? {s2_pal_q, tmm_data_i} : '0;

  AST_NO_COLOUR_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx_o != '0) |-> (cmp_en_i && hit_o)); // R7

  AST_ADDR_CARRIES_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok_q && s1_hit_q) |-> (tmm_addr_o[ADDR_W-1 -: TILE_W] == $past(attr.tile))); // R4

  AST_PALETTE_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (cidx_o != '0) |-> (cidx_o[CIDX_W-1 -: PAL_W] == s2_pal_q)); // R6
endmodule

// File: tb/sim_fg_sprite_slot.sv
module sim_fg_sprite_slot;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        vblank_i, attr_load_i, cmp_en_i;
  logic [31:0] attr_word_i;
  logic [8:0]  pix_x_i;
  logic [7:0]  pix_y_i;
  logic [17:0] tmm_addr_o;
  logic [2:0]  tmm_data_i;
  logic        hit_o;
  logic [5:0]  cidx_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int m_tile, m_h, m_v, m_pal, m_px, m_py;

  always #10 clk = ~clk;

  fg_sprite_slot u0 (
    .clk(clk), .rst_n(rst_n), .vblank_i(vblank_i), .attr_load_i(attr_load_i),
    .attr_word_i(attr_word_i), .pix_x_i(pix_x_i), .pix_y_i(pix_y_i),
    .tmm_addr_o(tmm_addr_o), .tmm_data_i(tmm_data_i), .cmp_en_i(cmp_en_i),
    .hit_o(hit_o), .cidx_o(cidx_o)
  );

  function automatic logic [2:0] texel(input logic [17:0] a);
    return a[2:0] ^ a[6:4] ^ a[10:8] ^ {a[3], a[7], a[11]} ^ a[15:13];
  endfunction

  always_ff @(posedge clk) tmm_data_i <= texel(tmm_addr_o);

  task automatic fail(input string req, input string what, input int act, input int exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic load_attr(input int tile, input int h, input int v, input int pal,
                           input int px, input int py, input bit vb, input bit ld);
    @(negedge clk);
    vblank_i    = vb;
    attr_load_i = ld;
    attr_word_i = {py[7:0], px[8:0], pal[2:0], v[0], h[0], tile[9:0]};
    @(negedge clk);
    vblank_i    = 1'b0;
    attr_load_i = 1'b0;
    if (vb && ld) begin
      m_tile = tile; m_h = h; m_v = v; m_pal = pal; m_px = px; m_py = py;
    end
  endtask

  task automatic check_pixel(input int x, input int y, input bit en);
    int ox, oy, c, r, eaddr, ecidx;
    bit ehit;
    ox   = x + 15 - m_px;
    oy   = y + 15 - m_py;
    ehit = (ox >= 0) && (ox <= 15) && (oy >= 0) && (oy <= 15);
    c    = m_h ? 15 - ox : ox;
    r    = m_v ? 15 - oy : oy;
    eaddr = m_tile * 256 + r * 16 + c;
    @(negedge clk);
    pix_x_i  = x[8:0];
    pix_y_i  = y[7:0];
    cmp_en_i = en;
    @(posedge clk); #1;
    if (ehit) begin
      checks++;
      if (tmm_addr_o !== eaddr[17:0]) fail("R4/R5", "texel address", tmm_addr_o, eaddr);
    end
    @(posedge clk); #1;
    ecidx = (ehit && en) ? (m_pal * 8 + texel(eaddr[17:0])) : 0;
    checks++;
    if (hit_o !== ehit) fail("R3/R6", "hit", hit_o, ehit);
    checks++;
    if (cidx_o !== ecidx[5:0]) fail(en ? "R6" : "R7", "colour index", cidx_o, ecidx);
  endtask

  task automatic sweep(input int px, input int py, input int k);
    for (int y = py - 17; y <= py + 2; y++) begin
      for (int x = px - 17; x <= px + 2; x++) begin
        if (x >= 0 && x < 320 && y >= 0 && y < 240)
          check_pixel(x, y, ((x + y + k) % 7) != 0);
      end
    end
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int px_l[4], py_l[4];
    rst_n = 1'b0; vblank_i = 1'b0; attr_load_i = 1'b0; cmp_en_i = 1'b1;
    attr_word_i = '0; pix_x_i = '0; pix_y_i = '0;
    m_tile = 0; m_h = 0; m_v = 0; m_pal = 0; m_px = 0; m_py = 0;
    #45;
    checks++;
    if (hit_o !== 1'b0) fail("R1", "hit in reset", hit_o, 0);
    checks++;
    if (cidx_o !== 6'd0) fail("R1", "cidx in reset", cidx_o, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: zero attribute covers only (0,0) with tile 0, palette 0
    check_pixel(0, 0, 1'b1);
    check_pixel(1, 0, 1'b1);
    check_pixel(0, 1, 1'b1);
    check_pixel(5, 5, 1'b1);

    px_l = '{0, 100, 7, 330};
    py_l = '{0, 40, 120, 250};
    for (int p = 0; p < 4; p++) begin
      for (int f = 0; f < 4; f++) begin
        // R2: fields placed per the word layout
        load_attr(37 * p + 201 * f + 5, f & 1, f >> 1, (p + 3 * f) & 7,
                  px_l[p], py_l[p], 1'b1, 1'b1);
        sweep(px_l[p], py_l[p], p + f);
      end
    end

    // R8: strobe outside blanking, and blanking without strobe, are ignored
    load_attr(700, 1, 1, 5, 200, 100, 1'b1, 1'b1);
    load_attr(3, 0, 0, 2, 50, 50, 1'b0, 1'b1);
    check_pixel(190, 90, 1'b1);
    check_pixel(40, 40, 1'b1);
    load_attr(9, 0, 0, 1, 60, 60, 1'b1, 1'b0);
    check_pixel(200, 100, 1'b1);
    check_pixel(50, 50, 1'b1);

    // R7: enable low while covered
    check_pixel(195, 95, 1'b0);
    check_pixel(196, 96, 1'b1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule